// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block turns simple access requests into the strobe sequences that an asynchronous extended-data-out DRAM array expects. Each request carries a read/write flag, a row address, a column address and write data. The block puts the row on the shared address pins and drops RAS. It then puts the column on the same pins and drops CAS. A write is issued as an early write, with W low before CAS falls. A read samples the data pins a fixed number of clocks after CAS falls and returns the word with a one-cycle valid pulse.

While a row is open, the next request is examined when the current column's CAS low time ends. If it targets the same row and the RAS low time still has room, the row stays open and only CAS cycles again (hyper-page burst). Otherwise CAS rises, RAS is held low until its minimum pulse width is met, and then it rises for the precharge. An external refresh grant blocks new rows and ends open bursts. All analog timing is given as whole clock counts in parameters.

Top module: `edo_dram_sequencer`

## Requirements
- R1: During and after reset with no request, dramRasN, dramCasN, dramWeN and dramOeN are 1, dramDqOe is 0, and busy and rdValid are 0.
- R2: The row sits on dramAddr when RAS falls. CAS is low only while RAS is low. The first CAS of a row falls ROW_HOLD_CYC+COL_SETUP_CYC cycles after RAS falls, with the column on dramAddr.
- R3: For a read, dramWeN is 1 in the cycle before CAS falls and while CAS is low, and dramOeN is 0 while CAS is low. rdData is the value on dramDqIn RD_SAMPLE_CYC cycles after CAS falls, and rdValid is high for exactly one cycle per read.
- R4: For a write, dramWeN is 0 and dramDqOe is 1 from the cycle before CAS falls through CAS low, dramOeN stays 1, and the data written equals reqWdata.
- R5: A request for the open row that is pending when a column's CAS low time ends is taken without RAS rising. CAS then stays high for CAS_PRE_CYC cycles before the next column.
- R6: A request for another row, or no pending request, ends the burst. RAS rises and stays high for at least RAS_PRE_CYC cycles before the next RAS fall.
- R7: Every RAS low pulse lasts at least RAS_MIN_CYC cycles.
- R8: No RAS low pulse exceeds RAS_MAX_CYC cycles. A same-row stream that would exceed it is split over several RAS pulses.
- R9: While refreshHold is 1, no request is taken, RAS does not fall, and an open burst ends instead of taking the next column.
- R10: reqTaken pulses in the cycle a request is taken. busy is 1 from the cycle after acceptance until the RAS precharge ends, including every RAS low cycle and the first cycle after RAS rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRow | input | ROW_W | Row address |
| reqCol | input | COL_W | Column address |
| reqWdata | input | DATA_W | Write data |
| refreshHold | input | 1 | Refresh grant; blocks new accesses |
| reqTaken | output | 1 | Request accepted this cycle |
| busy | output | 1 | Access or precharge in progress |
| rdValid | output | 1 | One-cycle read data strobe |
| rdData | output | DATA_W | Read data |
| dramAddr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramDqOut | output | DATA_W | Write data to the array |
| dramDqOe | output | 1 | Drive enable for dramDqOut |
| dramDqIn | input | DATA_W | Data from the array |

## Verification
The bench streams same-row requests long enough to cross the RAS low limit. A design that ignored the limit would hold RAS low past RAS_MAX_CYC, and one that computed it wrongly would never split the stream. It switches rows in mid-burst and expects a fresh RAS pulse with full precharge. A sequencer that kept the row open would write or read the wrong cells, and the scoreboard sees that as bad read data. It raises the refresh grant both while idle and right after a row opens, and a design that leaked a column through the grant would show an extra acceptance. At every CAS fall the bench checks the W and OE levels, so a late W or an enabled output during a write shows up at once.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // no row open
    ST_ASR,    // row address set up, RAS still high
    ST_RAH,    // RAS low, row address held
    ST_ASC,    // column address set up, CAS high
    ST_CASLO,  // CAS low for one column
    ST_CP,     // CAS precharge between burst columns
    ST_HOLD,   // CAS high, RAS kept low for its minimum width
    ST_PRE     // RAS precharge
  } seqState_t;

  typedef struct packed {
    logic loadReq;   // capture the accepted request
    logic selCol;    // address mux: 1 = column, 0 = row
    logic capture;   // sample read data from the array
  } dpStrobe_t;

endpackage

// File: rtl/edo_seq_dp.sv
module edo_seq_dp
  import edo_seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 11,
  parameter int DATA_W = 72,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              reqWrite,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] dramDqIn,
  output logic [ADDR_W-1:0] dramAddr,
  output logic [DATA_W-1:0] dramDqOut,
  output logic              curWr,
  output logic              sameRow,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  logic [ROW_W-1:0]  curRow;
  logic [COL_W-1:0]  curCol;
  logic [DATA_W-1:0] curData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curRow  <= '0;
      curCol  <= '0;
      curWr   <= 1'b0;
      curData <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      if (strobe.loadReq) begin
        curRow  <= reqRow;
        curCol  <= reqCol;
        curWr   <= reqWrite;
        curData <= reqWdata;
      end
      rdValid <= strobe.capture;
      if (strobe.capture) rdData <= dramDqIn;
    end
  end

  assign dramAddr  = strobe.selCol ? ADDR_W'(curCol) : ADDR_W'(curRow);
  assign dramDqOut = curData;
  assign sameRow   = (reqRow == curRow);

  // R3: each read returns one single-cycle strobe
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

endmodule

// File: rtl/edo_seq_ctrl.sv
module edo_seq_ctrl
  import edo_seq_pkg::*;
#(
  parameter int ROW_HOLD_CYC  = 1,
  parameter int COL_SETUP_CYC = 1,
  parameter int CAS_LOW_CYC   = 2,
  parameter int CAS_PRE_CYC   = 1,
  parameter int RD_SAMPLE_CYC = 2,
  parameter int RAS_MIN_CYC   = 5,
  parameter int RAS_MAX_CYC   = 20000,
  parameter int RAS_PRE_CYC   = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      refreshHold,
  input  logic      sameRow,
  input  logic      curWr,
  output dpStrobe_t strobe,
  output logic      reqTaken,
  output logic      busy,
  output logic      rasN,
  output logic      casN,
  output logic      weN,
  output logic      oeN,
  output logic      dqOe
);

  localparam int CNT_W = $clog2(ROW_HOLD_CYC + COL_SETUP_CYC + CAS_LOW_CYC
                                + CAS_PRE_CYC + RAS_PRE_CYC + 1);
  localparam int RAS_W = $clog2(RAS_MAX_CYC + 2);
  // last RAS count at which another column (precharge, CAS low, one hold cycle) still fits
  localparam logic [RAS_W-1:0] LAST_COL_AT = RAS_W'(RAS_MAX_CYC - CAS_PRE_CYC - CAS_LOW_CYC - 2);
  localparam logic [RAS_W-1:0] MIN_AT      = RAS_W'(RAS_MIN_CYC - 1);
  localparam logic [RAS_W-1:0] MAX_V       = RAS_W'(RAS_MAX_CYC);
  localparam logic [CNT_W-1:0] CAP_AT      = CNT_W'(CAS_LOW_CYC - RD_SAMPLE_CYC);

  seqState_t        st, stNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [RAS_W-1:0] rasCnt;
  logic             phaseDone, canAccept, canExtend;

  assign phaseDone = (cnt == '0);
  assign canAccept = reqValid && !refreshHold;
  assign canExtend = canAccept && sameRow && (rasCnt <= LAST_COL_AT);

  always_comb begin
    stNxt          = st;
    cntNxt         = phaseDone ? cnt : cnt - CNT_W'(1);
    strobe.loadReq = 1'b0;
    strobe.capture = 1'b0;
    unique case (st)
      ST_IDLE: if (canAccept) begin
        strobe.loadReq = 1'b1;
        stNxt          = ST_ASR;
      end
      ST_ASR: begin
        stNxt  = ST_RAH;
        cntNxt = CNT_W'(ROW_HOLD_CYC - 1);
      end
      ST_RAH: if (phaseDone) begin
        stNxt  = ST_ASC;
        cntNxt = CNT_W'(COL_SETUP_CYC - 1);
      end
      ST_ASC, ST_CP: if (phaseDone) begin
        stNxt  = ST_CASLO;
        cntNxt = CNT_W'(CAS_LOW_CYC - 1);
      end
      ST_CASLO: begin
        strobe.capture = !curWr && (cnt == CAP_AT);
        if (phaseDone) begin
          if (canExtend) begin
            strobe.loadReq = 1'b1;
            stNxt          = ST_CP;
            cntNxt         = CNT_W'(CAS_PRE_CYC - 1);
          end else begin
            stNxt = ST_HOLD;
          end
        end
      end
      ST_HOLD: if (rasCnt >= MIN_AT) begin
        stNxt  = ST_PRE;
        cntNxt = CNT_W'(RAS_PRE_CYC - 1);
      end
      ST_PRE: if (phaseDone) stNxt = ST_IDLE;
      default: stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      rasCnt <= '0;
    end else begin
      st  <= stNxt;
      cnt <= cntNxt;
      if (st == ST_ASR)  rasCnt <= '0;
      else if (!rasN)    rasCnt <= rasCnt + RAS_W'(1);
    end
  end

  assign strobe.selCol = (st == ST_ASC) || (st == ST_CASLO) || (st == ST_CP) || (st == ST_HOLD);
  assign rasN     = !((st == ST_RAH) || strobe.selCol);
  assign casN     = (st != ST_CASLO);
  assign weN      = !(curWr && ((st == ST_ASC) || (st == ST_CASLO) || (st == ST_CP)));
  assign dqOe     = !weN;
  assign oeN      = !(!curWr && (st == ST_CASLO));
  assign busy     = (st != ST_IDLE);
  assign reqTaken = strobe.loadReq;

  // R2: column strobe only inside an open row
  assert_cas_in_ras_R2: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN);
  // R3: read column sees W high already and OE enabled
  assert_read_we_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN) && weN) |-> ($past(weN) && !oeN));
  // R4: early write, W low before CAS falls
  assert_early_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN) && !weN) |-> !$past(weN));
  // R4: never drive data while the array output is enabled
  assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> oeN);
  // R7: minimum RAS low width
  assert_ras_min_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> ($past(rasCnt) >= MIN_AT));
  // R8: maximum RAS low width
  assert_ras_max_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> (rasCnt < MAX_V));
  // R9: no row opened from a decision made under the refresh grant
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> !$past(refreshHold, 2));
  // R10: busy covers every RAS low cycle
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> busy);

endmodule

// File: rtl/edo_dram_sequencer.sv
module edo_dram_sequencer
  import edo_seq_pkg::*;
#(
  parameter int ROW_W         = 13,
  parameter int COL_W         = 11,
  parameter int DATA_W        = 72,
  parameter int ROW_HOLD_CYC  = 1,
  parameter int COL_SETUP_CYC = 1,
  parameter int CAS_LOW_CYC   = 2,
  parameter int CAS_PRE_CYC   = 1,
  parameter int RD_SAMPLE_CYC = 2,
  parameter int RAS_MIN_CYC   = 5,
  parameter int RAS_MAX_CYC   = 20000,
  parameter int RAS_PRE_CYC   = 3,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              refreshHold,
  output logic              reqTaken,
  output logic              busy,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] dramAddr,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              dramWeN,
  output logic              dramOeN,
  output logic [DATA_W-1:0] dramDqOut,
  output logic              dramDqOe,
  input  logic [DATA_W-1:0] dramDqIn
);

  dpStrobe_t strobe;
  logic      curWr, sameRow;

  edo_seq_ctrl #(
    .ROW_HOLD_CYC(ROW_HOLD_CYC), .COL_SETUP_CYC(COL_SETUP_CYC),
    .CAS_LOW_CYC(CAS_LOW_CYC), .CAS_PRE_CYC(CAS_PRE_CYC),
    .RD_SAMPLE_CYC(RD_SAMPLE_CYC), .RAS_MIN_CYC(RAS_MIN_CYC),
    .RAS_MAX_CYC(RAS_MAX_CYC), .RAS_PRE_CYC(RAS_PRE_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .refreshHold(refreshHold),
    .sameRow(sameRow), .curWr(curWr), .strobe(strobe), .reqTaken(reqTaken),
    .busy(busy), .rasN(dramRasN), .casN(dramCasN), .weN(dramWeN),
    .oeN(dramOeN), .dqOe(dramDqOe)
  );

  edo_seq_dp #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqRow(reqRow), .reqCol(reqCol), .reqWdata(reqWdata), .dramDqIn(dramDqIn),
    .dramAddr(dramAddr), .dramDqOut(dramDqOut), .curWr(curWr),
    .sameRow(sameRow), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: tb/edo_dram_sequencer_bench.sv
module edo_dram_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 4, CW = 4, DW = 16;
  localparam int T_RAH = 1, T_ASC = 1, T_CAS = 2, T_CP = 1, T_RD = 2;
  localparam int T_RMIN = 5, T_RMAX = 30, T_RP = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, refreshHold = 1'b0;
  logic [RW-1:0] reqRow = '0;
  logic [CW-1:0] reqCol = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqTaken, busy, rdValid, dramRasN, dramCasN, dramWeN, dramOeN, dramDqOe;
  logic [DW-1:0] rdData, dramDqOut, dramDqIn;
  logic [3:0] dramAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  edo_dram_sequencer #(
    .ROW_W(RW), .COL_W(CW), .DATA_W(DW), .ROW_HOLD_CYC(T_RAH),
    .COL_SETUP_CYC(T_ASC), .CAS_LOW_CYC(T_CAS), .CAS_PRE_CYC(T_CP),
    .RD_SAMPLE_CYC(T_RD), .RAS_MIN_CYC(T_RMIN), .RAS_MAX_CYC(T_RMAX),
    .RAS_PRE_CYC(T_RP)
  ) u_edo_dram_sequencer (.*);

  int checks = 0, errors = 0, takes = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] shadow [256];
  logic [DW-1:0] expQ [$];
  logic [RW-1:0] expRow = '0;
  logic [RW-1:0] mRow = '0;
  logic [CW-1:0] mCol = '0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // array model: row on RAS fall, column (and early-write data) on CAS fall
  initial for (int i = 0; i < 256; i++) begin
    mem[i] = DW'(i * 37 + 5);
    shadow[i] = mem[i];
  end
  always @(negedge dramRasN) mRow = dramAddr[RW-1:0];
  always @(negedge dramCasN) begin
    mCol = dramAddr[CW-1:0];
    if (!dramWeN) mem[{mRow, mCol}] = dramDqOut;
  end
  assign dramDqIn = !dramOeN ? mem[{mRow, mCol}] : '0;

  always @(posedge clk) if (rstN && reqTaken) takes++;

  // scoreboard monitor
  always @(negedge clk) if (rstN && rdValid) begin
    if (expQ.size() == 0) check(1'b0, "R3 unexpected rdValid", rdData, 0);
    else begin
      automatic logic [DW-1:0] e = expQ.pop_front();
      check(rdData == e, "R3 read data", rdData, e);
    end
  end

  // protocol monitor
  bit prevRas = 1, prevCas = 1, prevWe = 1, firstCas = 0;
  int rasLow = 0, rasHigh = 100, casHigh = 0, rasFalls = 0, casFalls = 0;
  always @(negedge clk) if (rstN) begin
    if (prevRas && !dramRasN) begin
      rasFalls++;
      check(rasHigh >= T_RP, "R6 RAS precharge width", rasHigh, T_RP);
      check(dramAddr == expRow, "R2 row at RAS fall", dramAddr, expRow);
      rasLow = 0;
      firstCas = 1;
    end
    if (!dramRasN) begin
      rasLow++;
      check(busy, "R10 busy while RAS low", busy, 1);
    end
    if (!prevRas && dramRasN) begin
      check(rasLow >= T_RMIN, "R7 RAS low minimum", rasLow, T_RMIN);
      check(rasLow <= T_RMAX, "R8 RAS low maximum", rasLow, T_RMAX);
      check(busy, "R10 busy in precharge", busy, 1);
      rasHigh = 0;
    end
    if (dramRasN) rasHigh++;
    if (prevCas && !dramCasN) begin
      casFalls++;
      if (firstCas) check(rasLow == T_RAH + T_ASC + 1, "R2 RAS-to-CAS delay", rasLow, T_RAH + T_ASC + 1);
      else check(casHigh >= T_CP, "R5 CAS precharge", casHigh, T_CP);
      firstCas = 0;
      if (!dramWeN) begin
        check(!prevWe, "R4 W low before CAS", prevWe, 0);
        check(dramOeN && dramDqOe, "R4 OE high and data driven", {dramOeN, dramDqOe}, 3);
      end else begin
        check(prevWe, "R3 W high before CAS", prevWe, 1);
        check(!dramOeN, "R3 OE low on read", dramOeN, 0);
      end
    end
    if (!dramCasN) casHigh = 0; else if (!dramRasN) casHigh++;
    prevRas = dramRasN; prevCas = dramCasN; prevWe = dramWeN;
  end

  task automatic issue(input bit wr, input logic [RW-1:0] row, input logic [CW-1:0] col,
                       input logic [DW-1:0] data);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqRow = row; reqCol = col; reqWdata = data;
    #1;
    while (!reqTaken) begin @(negedge clk); #1; end
    if (wr) shadow[{row, col}] = data;
    else expQ.push_back(shadow[{row, col}]);
    expRow = row;
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy || reqValid);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements): actual=hung expected=done");
    finishRun();
  end

  initial begin
    int r0, c0, t0;
    repeat (3) @(negedge clk);
    check({dramRasN, dramCasN, dramWeN, dramOeN} == 4'hF && !dramDqOe && !busy && !rdValid,
          "R1 reset state", {dramRasN, dramCasN, dramWeN, dramOeN, dramDqOe, busy, rdValid}, 7'b1111000);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(dramRasN && !busy && !rdValid, "R1 idle after reset", {dramRasN, busy, rdValid}, 3'b100);

    // single write then single read (R4, R3)
    issue(1, 2, 5, 16'hA5C3); waitIdle();
    check(mem[{4'd2, 4'd5}] == 16'hA5C3, "R4 written cell", mem[{4'd2, 4'd5}], 16'hA5C3);
    issue(0, 2, 5, 0); waitIdle();
    issue(0, 7, 3, 0); waitIdle();
    check(dramRasN && !busy, "R10 busy clears after precharge", busy, 0);

    // same-row burst (R5)
    r0 = rasFalls; c0 = casFalls;
    for (int i = 0; i < 4; i++) issue(0, 9, 4'(i), 0);
    issue(1, 9, 4, 16'h1234);
    waitIdle();
    check(rasFalls - r0 == 1, "R5 one RAS for same-row burst", rasFalls - r0, 1);
    check(casFalls - c0 == 5, "R5 one CAS per column", casFalls - c0, 5);

    // row change ends burst (R6)
    r0 = rasFalls;
    issue(0, 9, 4, 0);
    issue(0, 10, 1, 0);
    waitIdle();
    check(rasFalls - r0 == 2, "R6 row change reopens RAS", rasFalls - r0, 2);
    repeat (4) @(negedge clk);
    check(dramRasN, "R6 RAS high with no request", dramRasN, 1);

    // refresh grant while idle (R9)
    t0 = takes; refreshHold = 1'b1;
    fork issue(0, 6, 6, 0); join_none
    repeat (12) @(negedge clk);
    check(takes == t0 && dramRasN, "R9 no access under refresh grant", takes - t0, 0);
    refreshHold = 1'b0;
    wait fork;
    waitIdle();

    // refresh grant ends an open burst (R9)
    r0 = rasFalls;
    issue(0, 6, 7, 0);
    refreshHold = 1'b1;
    t0 = takes;
    fork issue(0, 6, 8, 0); join_none
    repeat (15) @(negedge clk);
    check(takes == t0 && dramRasN, "R9 burst ended by refresh grant", takes - t0, 0);
    refreshHold = 1'b0;
    wait fork;
    waitIdle();
    check(rasFalls - r0 == 2, "R9 second column in new RAS", rasFalls - r0, 2);

    // long same-row stream split by RAS maximum (R8)
    r0 = rasFalls;
    for (int i = 0; i < 12; i++) issue(0, 3, 4'(i), 0);
    waitIdle();
    check(rasFalls - r0 >= 2, "R8 stream split over RAS pulses", rasFalls - r0, 2);

    // mixed write/read burst with varied data (R4, R3, R5)
    for (int i = 0; i < 4; i++) issue(1, 5, 4'(i), DW'(16'hF00F ^ (i * 16'h0111)));
    for (int i = 0; i < 4; i++) issue(0, 5, 4'(3 - i), 0);
    waitIdle();

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R3 all reads returned", expQ.size(), 0);
    finishRun();
  end
endmodule